// File: doc/BRIEF.md
# Serial Window Bridge

This block turns CPU loads and stores that land in a 1 MiB address window into single-word requests for a serial packet engine. The engine talks to a remote controller that holds a boot ROM region (offsets 0x000 to 0x7BF) and a 64-byte RAM region (offsets 0x7C0 to 0x7FF). Only the low 11 offset bits matter, so the two regions repeat across the whole window. The bridge does not treat the regions differently: every hit produces a request, including stores aimed at ROM.

Loads hold the CPU stalled until the remote word comes back. Stores are posted, so the CPU moves on while the serial write runs. A load that arrives while a store is still in flight waits behind it and starts once the store completes. A second store that arrives during a posted store also waits. Two busy flags and an interrupt pulse report the progress of a posted store. The last word address and data word are visible to a neighbouring register block.

Top module: `serial_window_bridge`

## Requirements
- R1: An access hits only when address bits 31..20 equal 0x1FC. A strobe outside the window keeps `cpu_stall_o` low, issues no request and leaves the busy flags low.
- R2: The request word address is CPU address bits 10..2. Bits 19..11 and 1..0 are ignored, so addresses that differ only in those bits reach the same remote word.
- R3: A store to the ROM offsets (0x000 to 0x7BF) issues a write request exactly like a store to the RAM offsets.
- R4: A load that hits stalls the CPU until the response arrives. `cpu_rdata_o` carries the returned word in the first cycle with the stall low, which is the cycle after `rsp_valid_i`.
- R5: A store that hits while the bridge is idle completes with no stall cycle.
- R6: Only one posted store is in flight at a time. A store that arrives while one is in flight stalls until the earlier store's response has arrived.
- R7: A load that arrives during a posted store raises `rd_pending_o`, issues no read request until the store completes, and then returns the data the store wrote.
- R8: `io_busy_o` and `dma_busy_o` are both high from the cycle after a store is accepted until its response arrives. Both stay low during a load that starts from idle.
- R9: `irq_o` pulses high for exactly one cycle, in the cycle after a store's response. A load raises no pulse.
- R10: `req_cmd_o` is 2'b11 for a read and 2'b10 for a write. While `req_valid_o` is high and `req_ready_i` is low, the command, address and write data stay stable.
- R11: `cur_addr_o` holds the word address of the last accepted access. `cur_data_o` holds the last store's data or the last load's returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_wdata_i | input | 32 | CPU store data |
| cpu_rd_i | input | 1 | Load strobe, held until the stall drops |
| cpu_wr_i | input | 1 | Store strobe, held until the stall drops |
| cpu_rdata_o | output | 32 | Load data, valid when the stall is low |
| cpu_stall_o | output | 1 | CPU must hold its access |
| req_valid_o | output | 1 | Request to the serial engine |
| req_ready_i | input | 1 | Serial engine takes the request |
| req_cmd_o | output | 2 | Command code: 2'b11 read, 2'b10 write |
| req_addr_o | output | 9 | Remote word address |
| req_wdata_o | output | 32 | Write data for the request |
| rsp_valid_i | input | 1 | Request finished on the serial side |
| rsp_rdata_i | input | 32 | Read data with the response |
| io_busy_o | output | 1 | Posted store in flight |
| dma_busy_o | output | 1 | Transfer busy, also set by a posted store |
| rd_pending_o | output | 1 | Load held behind a store |
| irq_o | output | 1 | One-cycle pulse when a store completes |
| cur_addr_o | output | 9 | Current word address register |
| cur_data_o | output | 32 | Current data word register |

## Verification
A sequencer stuck in a write state shows at the ports as busy flags that never drop and as every later load stalling forever. A wrong return to idle shows within one response as a missing interrupt pulse, or as a read request issued while `rd_pending_o` is high. A bad data register shows in the first unstalled load cycle as wrong `cpu_rdata_o`, or on the request lines as a wrong address or wrong write data at the remote model. Running stores and loads in a fixed order against a remote memory model, then reading the words back, shows each of these within a few cycles of the access that causes it.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int CMD_W = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_WR = 2'b10,
    CMD_RD = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_WWAIT,
    ST_RREQ,
    ST_RWAIT,
    ST_RDONE
  } seq_state_e;
endpackage

// File: rtl/swb_decode.sv
module swb_decode #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 20,
  parameter int OFS_W     = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1FC0_0000,
  localparam int WADDR_W  = OFS_W - 2
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o,
  output logic [WADDR_W-1:0] waddr_o
);
  logic unused_ofs;

  assign hit_o      = (addr_i[ADDR_W-1:SPAN_LOG2] == WIN_BASE[ADDR_W-1:SPAN_LOG2]);
  assign waddr_o    = addr_i[OFS_W-1:2];
  // mirrored and byte-lane bits carry no meaning
  assign unused_ofs = ^{addr_i[SPAN_LOG2-1:OFS_W], addr_i[1:0], WIN_BASE[SPAN_LOG2-1:0]};
endmodule

// File: rtl/swb_seq.sv
module swb_seq
  import swb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_hit_i,
  input  logic       wr_hit_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  output logic       stall_o,
  output logic       req_valid_o,
  output cmd_e       req_cmd_o,
  output logic       wr_busy_o,
  output logic       rd_pending_o,
  output logic       irq_o,
  output logic       wr_accept_o,
  output logic       rd_start_o,
  output logic       rd_capture_o
);
  seq_state_e state_q, state_d;
  logic       irq_q;
  logic       wr_done;

  assign wr_accept_o  = (state_q == ST_IDLE) && wr_hit_i;
  assign rd_start_o   = (state_q == ST_IDLE) && rd_hit_i && !wr_hit_i;
  assign rd_capture_o = (state_q == ST_RWAIT) && rsp_valid_i;
  assign wr_done      = (state_q == ST_WWAIT) && rsp_valid_i;
  assign wr_busy_o    = (state_q == ST_WREQ) || (state_q == ST_WWAIT);
  assign rd_pending_o = rd_hit_i && wr_busy_o;
  assign req_valid_o  = (state_q == ST_WREQ) || (state_q == ST_RREQ);
  assign req_cmd_o    = wr_busy_o ? CMD_WR : CMD_RD;
  assign stall_o      = (rd_hit_i && (state_q != ST_RDONE)) ||
                        (wr_hit_i && (state_q != ST_IDLE));
  assign irq_o        = irq_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (wr_hit_i) state_d = ST_WREQ;
                else if (rd_hit_i) state_d = ST_RREQ;
      ST_WREQ:  if (req_ready_i) state_d = ST_WWAIT;
      ST_WWAIT: if (rsp_valid_i) state_d = ST_IDLE;
      ST_RREQ:  if (req_ready_i) state_d = ST_RWAIT;
      ST_RWAIT: if (rsp_valid_i) state_d = ST_RDONE;
      ST_RDONE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= wr_done;
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wr_busy_o)); // R9
  AST_RD_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_i && !stall_o) |-> $past(rsp_valid_i)); // R4
  AST_PENDING_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pending_o |-> !(req_valid_o && req_cmd_o == CMD_RD)); // R7
  AST_REQ_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_cmd_o))); // R10
endmodule

// File: rtl/swb_cur_regs.sv
module swb_cur_regs #(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_accept_i,
  input  logic               rd_start_i,
  input  logic               rd_capture_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  rsp_rdata_i,
  output logic [WADDR_W-1:0] cur_addr_o,
  output logic [DATA_W-1:0]  cur_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_o <= '0;
      cur_data_o <= '0;
    end else begin
      if (wr_accept_i || rd_start_i) cur_addr_o <= waddr_i;
      if (wr_accept_i)               cur_data_o <= wdata_i;
      else if (rd_capture_i)         cur_data_o <= rsp_rdata_i;
    end
  end

  AST_ADDR_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_accept_i || rd_start_i) |=> (cur_addr_o == $past(waddr_i))); // R11
  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_accept_i && !rd_capture_i) |=> $stable(cur_data_o)); // R11
endmodule

// File: rtl/serial_window_bridge.sv
module serial_window_bridge
  import swb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 20,
  parameter int OFS_W     = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1FC0_0000,
  localparam int WADDR_W  = OFS_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  input  logic               cpu_rd_i,
  input  logic               cpu_wr_i,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  output logic               cpu_stall_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [CMD_W-1:0]   req_cmd_o,
  output logic [WADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0]  req_wdata_o,
  input  logic               rsp_valid_i,
  input  logic [DATA_W-1:0]  rsp_rdata_i,
  output logic               io_busy_o,
  output logic               dma_busy_o,
  output logic               rd_pending_o,
  output logic               irq_o,
  output logic [WADDR_W-1:0] cur_addr_o,
  output logic [DATA_W-1:0]  cur_data_o
);
  logic               hit, rd_hit, wr_hit;
  logic [WADDR_W-1:0] waddr;
  logic               wr_accept, rd_start, rd_capture, wr_busy;
  cmd_e               cmd;

  swb_decode #(
    .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)
  ) u_decode (
    .addr_i (cpu_addr_i),
    .hit_o  (hit),
    .waddr_o(waddr)
  );

  assign rd_hit = cpu_rd_i && hit;
  assign wr_hit = cpu_wr_i && hit;

  swb_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_hit_i    (rd_hit),
    .wr_hit_i    (wr_hit),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .stall_o     (cpu_stall_o),
    .req_valid_o (req_valid_o),
    .req_cmd_o   (cmd),
    .wr_busy_o   (wr_busy),
    .rd_pending_o(rd_pending_o),
    .irq_o       (irq_o),
    .wr_accept_o (wr_accept),
    .rd_start_o  (rd_start),
    .rd_capture_o(rd_capture)
  );

  swb_cur_regs #(.DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_cur (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_accept_i (wr_accept),
    .rd_start_i  (rd_start),
    .rd_capture_i(rd_capture),
    .waddr_i     (waddr),
    .wdata_i     (cpu_wdata_i),
    .rsp_rdata_i (rsp_rdata_i),
    .cur_addr_o  (cur_addr_o),
    .cur_data_o  (cur_data_o)
  );

  assign req_cmd_o   = cmd;
  assign req_addr_o  = cur_addr_o;
  assign req_wdata_o = cur_data_o;
  assign cpu_rdata_o = cur_data_o;
  // a posted store counts as a transfer for both flags
  assign io_busy_o   = wr_busy;
  assign dma_busy_o  = wr_busy;

  AST_REQ_PAYLOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> ($stable(req_addr_o) && $stable(req_wdata_o))); // R10
  AST_MISS_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_rd_i || cpu_wr_i) && !hit) |-> !cpu_stall_o); // R1
  AST_WR_POSTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !cpu_stall_o) |=> io_busy_o); // R5
endmodule

// File: tb/sim_serial_window_bridge.sv
`timescale 1ns/1ps
module sim_serial_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        req_valid, req_ready = 1'b0;
  logic [1:0]  req_cmd;
  logic [8:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        io_busy, dma_busy, rd_pending, irq;
  logic [8:0]  cur_addr;
  logic [31:0] cur_data;

  always #2 clk = ~clk;

  serial_window_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_rdata_o(cpu_rdata), .cpu_stall_o(cpu_stall),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_cmd_o(req_cmd),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
    .io_busy_o(io_busy), .dma_busy_o(dma_busy), .rd_pending_o(rd_pending), .irq_o(irq),
    .cur_addr_o(cur_addr), .cur_data_o(cur_data)
  );

  int checks = 0, fails = 0;
  int irq_cnt = 0, req_cnt = 0;
  int gap = 1, lat = 4;
  logic [31:0] mem [512];
  logic [1:0]  log_cmd [16];
  logic [8:0]  log_addr [16];
  logic        done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // remote side model
  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'hA500_0000 ^ i;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        repeat (gap) @(negedge clk);
        log_cmd[req_cnt % 16]  = req_cmd;
        log_addr[req_cnt % 16] = req_addr;
        req_cnt++;
        if (req_cmd == 2'b10) mem[req_addr] = req_wdata;
        rsp_rdata = mem[req_addr];
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq) irq_cnt++;
  end

  task automatic cpu_access(input bit is_wr, input logic [31:0] a, input logic [31:0] wd,
                            output logic [31:0] rd_data, output int st,
                            output bit pend, output bit busy);
    st = 0; pend = 0; busy = 0;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd;
    if (is_wr) cpu_wr = 1'b1; else cpu_rd = 1'b1;
    forever begin
      #1;
      if (rd_pending) pend = 1;
      if (io_busy || dma_busy) busy = 1;
      if (!cpu_stall) begin
        rd_data = cpu_rdata;
        break;
      end
      st++;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((io_busy || req_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  // {is_write, address, write data or expected read data}
  localparam logic [64:0] VEC [8] = '{
    {1'b1, 32'h1FC0_07C0, 32'h1111_2222},
    {1'b0, 32'h1FC0_07C0, 32'h1111_2222},
    {1'b1, 32'h1FC0_0010, 32'h3333_4444},
    {1'b0, 32'h1FCF_F010, 32'h3333_4444},
    {1'b0, 32'h1FC0_07FC, 32'hA500_01FF},
    {1'b1, 32'h1FC8_07FC, 32'h5555_6666},
    {1'b0, 32'h1FC0_07FC, 32'h5555_6666},
    {1'b0, 32'h1FC0_0002, 32'hA500_0000}
  };

  initial begin
    logic [31:0] d;
    int st, irq0, req0;
    bit pend, busy;

    repeat (3) @(negedge clk);
    #1;
    check(!cpu_stall && !req_valid, "R1", "reset stall/req", {cpu_stall, req_valid}, 0);
    check(!io_busy && !dma_busy && !irq, "R8", "reset busy/irq", {io_busy, dma_busy, irq}, 0);
    check(cur_addr == 0 && cur_data == 0, "R11", "reset current regs", cur_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      bit          w  = VEC[i][64];
      logic [31:0] a  = VEC[i][63:32];
      logic [31:0] dv = VEC[i][31:0];
      irq0 = irq_cnt; req0 = req_cnt;
      cpu_access(w, a, dv, d, st, pend, busy);
      if (w) begin
        check(st == 0, "R5", "store stall cycles", st, 0);
        #1;
        check(io_busy && dma_busy, "R8", "busy during store", {io_busy, dma_busy}, 2'b11);
      end
      wait_idle();
      check(req_cnt == req0 + 1, "R3", "one request per access", req_cnt - req0, 1);
      check(log_addr[req0 % 16] == a[10:2], "R2", "word address", log_addr[req0 % 16], a[10:2]);
      check(log_cmd[req0 % 16] == (w ? 2'b10 : 2'b11), "R10", "command code",
            log_cmd[req0 % 16], w ? 2'b10 : 2'b11);
      check(cur_addr == a[10:2], "R11", "current address", cur_addr, a[10:2]);
      check(cur_data == dv, "R11", "current data", cur_data, dv);
      if (w) begin
        check(irq_cnt == irq0 + 1, "R9", "store irq pulses", irq_cnt - irq0, 1);
      end else begin
        check(d == dv, "R4", "load data", d, dv);
        check(st > lat, "R4", "load stalled", st, lat + 1);
        check(!busy, "R8", "busy during load", busy, 0);
        check(irq_cnt == irq0, "R9", "load irq pulses", irq_cnt - irq0, 0);
      end
    end

    // outside the window
    req0 = req_cnt;
    cpu_access(1'b1, 32'h1FD0_07C0, 32'hDEAD_BEEF, d, st, pend, busy);
    cpu_access(1'b0, 32'h0000_07C0, 32'h0, d, st, pend, busy);
    repeat (10) @(negedge clk);
    check(st == 0, "R1", "miss stall", st, 0);
    check(req_cnt == req0, "R1", "miss requests", req_cnt - req0, 0);
    check(!io_busy && !dma_busy, "R1", "miss busy", {io_busy, dma_busy}, 0);

    // back-to-back stores, second one waits
    gap = 3; irq0 = irq_cnt; req0 = req_cnt;
    cpu_access(1'b1, 32'h1FC0_07C8, 32'hAAAA_0001, d, st, pend, busy);
    cpu_access(1'b1, 32'h1FC0_07CC, 32'hAAAA_0002, d, st, pend, busy);
    check(st > 0, "R6", "second store stalled", st, 1);
    wait_idle();
    check(req_cnt == req0 + 2, "R6", "two write requests", req_cnt - req0, 2);
    check(log_addr[(req0 + 1) % 16] == 9'h1F3, "R6", "second store order",
          log_addr[(req0 + 1) % 16], 9'h1F3);
    check(irq_cnt == irq0 + 2, "R9", "two irq pulses", irq_cnt - irq0, 2);

    // load behind a posted store
    gap = 1; req0 = req_cnt;
    cpu_access(1'b1, 32'h1FC0_07D0, 32'hBEEF_0007, d, st, pend, busy);
    cpu_access(1'b0, 32'h1FC0_07D0, 32'h0, d, st, pend, busy);
    check(pend, "R7", "pending flag seen", pend, 1);
    check(d == 32'hBEEF_0007, "R7", "load after store data", d, 32'hBEEF_0007);
    check(log_cmd[req0 % 16] == 2'b10 && log_cmd[(req0 + 1) % 16] == 2'b11, "R7",
          "store before load", {log_cmd[req0 % 16], log_cmd[(req0 + 1) % 16]}, 4'b1011);
    wait_idle();
    check(!rd_pending, "R7", "pending cleared", rd_pending, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule